// File: doc/BRIEF.md
# Software Interrupt Controller

This block lets harts signal one another through memory-mapped registers laid out like a platform interrupt controller. Every hart owns exactly one interrupt source: the source aimed at hart h carries ID h+1. Source ID 0 does not exist. A hart raises an interrupt for a peer by setting that peer's bit in the shared pending word. The block drives one level-sensitive interrupt line per hart. That line is computed from the pending bits, the hart's own enable word and the per-source priorities.

The receiving hart reads its claim register to learn which source to service. The read hands back the most urgent eligible ID, clears that source's pending bit and marks the source as in service. When the hart writes the same ID back to the same register, the source is released. A request that arrives while its source is in service is held in the pending bit. It becomes visible again once the source is completed. Register access uses a single-cycle bus: read data is valid combinationally in the cycle the read is presented, and all side effects take place at the following clock edge.

Top module: `swi_ctrl`

## Requirements
- R1: After reset, all priorities, pending bits, enable bits and in-service marks are zero, and every interrupt line is low.
- R2: The pending word sits at offset 0x1000 and holds source n at bit n. Writing a one to a bit sets that pending bit. Writing a zero leaves the bit unchanged. Bit 0 and the bits above NUM_HARTS always read as zero.
- R3: Source n (1..NUM_HARTS) has a priority word at offset 4*n. Only the low PRIO_W bits are stored; the upper bits read as zero. Offset 0 reads as zero.
- R4: The enable word for hart h sits at offset 0x2000 + h*0x80 and holds source n at bit n. Bit 0 and unused bits read as zero.
- R5: Interrupt line h is high exactly when some source is pending, enabled for hart h, has a nonzero priority and is not in service.
- R6: A read of the claim register of hart h at offset 0x200004 + h*0x1000 returns the eligible source with the highest priority; on equal priority it returns the lowest ID. At the following edge, that read clears the source's pending bit and marks the source as in service for hart h.
- R7: A claim read when hart h has no eligible source returns 0 and changes no state.
- R8: Writing ID n to hart h's claim register ends service of source n only if hart h holds n in service. Any other written value is ignored.
- R9: A pending write to a source that is in service is retained. The source raises no interrupt until it is completed, and after completion it is eligible again.
- R10: Reads of unmapped or misaligned offsets return zero, and writes to them change no state. The read data is zero whenever no read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| irq_out | output | NUM_HARTS | Interrupt line per hart |

## Verification
Completion and re-arming can coincide. A completion write can release a source whose pending bit was set again while it was in service. The interrupt line must then rise at the very edge that clears the in-service mark. The bench provokes this directly, and again at random, by setting a source's pending bit between its claim and its completion. It then compares the interrupt vector, and the next claim result, with a model that applies the release and the stored request together.

// File: rtl/swi_ctrl.sv
module swi_ctrl #(
  parameter int NUM_HARTS = 4,
  parameter int PRIO_W    = 3,
  parameter int ADDR_W    = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_HARTS-1:0] irq_out
);
  localparam int NS  = NUM_HARTS;
  localparam int IDW = $clog2(NS + 1);
  localparam int HIW = ADDR_W - 12;
  localparam int TPW = ADDR_W - 21;

  logic [PRIO_W-1:0] prio_q [1:NS];
  logic [NS:1]       pend_q;
  logic [NS:1]       en_q   [NS];
  logic [NS:1]       busy_q [NS];
  logic [NS:1]       elig   [NS];
  logic [NS:1]       nz, infl, cand;
  logic [IDW-1:0]    win_id;
  logic [PRIO_W-1:0] win_p;

  wire rd = bus_sel & ~bus_wr;
  wire wr = bus_sel &  bus_wr;

  wire [HIW-1:0] hi       = bus_addr[ADDR_W-1:12];
  wire [9:0]     prio_idx = bus_addr[11:2];
  wire [4:0]     en_idx   = bus_addr[11:7];
  wire [8:0]     clm_idx  = bus_addr[20:12];

  wire hit_pend = (hi == HIW'(1)) && (bus_addr[11:0] == 12'h000);
  wire hit_prio = (hi == '0) && (bus_addr[1:0] == 2'b00) &&
                  (prio_idx != 10'd0) && (int'(prio_idx) <= NS);
  wire hit_en   = (hi == HIW'(2)) && (bus_addr[6:0] == 7'd0) && (int'(en_idx) < NS);
  wire hit_clm  = (bus_addr[ADDR_W-1:21] == TPW'(1)) && (int'(clm_idx) < NS) &&
                  (bus_addr[11:0] == 12'h004);

  always_comb begin
    infl = '0;
    for (int h = 0; h < NS; h++) infl = infl | busy_q[h];
    for (int n = 1; n <= NS; n++) nz[n] = (prio_q[n] != '0);
  end

  for (genvar h = 0; h < NS; h++) begin : g_hart
    assign elig[h]    = pend_q & en_q[h] & nz & ~infl;
    assign irq_out[h] = |elig[h];
  end

  always_comb begin
    cand = '0;
    for (int h = 0; h < NS; h++)
      if (int'(clm_idx) == h) cand = elig[h];
    win_id = '0;
    win_p  = '0;
    for (int n = 1; n <= NS; n++)
      if (cand[n] && (prio_q[n] > win_p)) begin
        win_p  = prio_q[n];
        win_id = IDW'(n);
      end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (hit_pend) bus_rdata = 32'({pend_q, 1'b0});
      if (hit_prio)
        for (int n = 1; n <= NS; n++)
          if (int'(prio_idx) == n) bus_rdata = 32'(prio_q[n]);
      if (hit_en)
        for (int h = 0; h < NS; h++)
          if (int'(en_idx) == h) bus_rdata = 32'({en_q[h], 1'b0});
      if (hit_clm) bus_rdata = 32'(win_id);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      for (int n = 1; n <= NS; n++) prio_q[n] <= '0;
      for (int h = 0; h < NS; h++) begin
        en_q[h]   <= '0;
        busy_q[h] <= '0;
      end
    end else begin
      if (wr && hit_pend) pend_q <= pend_q | bus_wdata[NS:1];
      if (wr && hit_prio)
        for (int n = 1; n <= NS; n++)
          if (int'(prio_idx) == n) prio_q[n] <= bus_wdata[PRIO_W-1:0];
      if (wr && hit_en)
        for (int h = 0; h < NS; h++)
          if (int'(en_idx) == h) en_q[h] <= bus_wdata[NS:1];
      if (wr && hit_clm)
        for (int h = 0; h < NS; h++)
          if (int'(clm_idx) == h)
            for (int n = 1; n <= NS; n++)
              if (bus_wdata == 32'(n)) busy_q[h][n] <= 1'b0;
      if (rd && hit_clm && (win_id != '0))
        for (int h = 0; h < NS; h++)
          if (int'(clm_idx) == h)
            for (int n = 1; n <= NS; n++)
              if (win_id == IDW'(n)) begin
                pend_q[n]    <= 1'b0;
                busy_q[h][n] <= 1'b1;
              end
    end
  end
endmodule

// File: rtl/swi_ctrl_chk.sv
module swi_ctrl_chk #(
  parameter int NUM_HARTS = 4,
  parameter int PRIO_W    = 3,
  parameter int ADDR_W    = 22
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_sel,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [NUM_HARTS-1:0] irq_out
);
  wire rd = bus_sel && !bus_wr;

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_out == '0));

  p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (bus_rdata == 32'd0));

  p_misaligned_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (bus_addr[1:0] != 2'b00)) |-> (bus_rdata == 32'd0));

  p_pend_bit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (bus_addr == ADDR_W'(32'h1000))) |->
      ((bus_rdata[0] == 1'b0) && ((bus_rdata >> (NUM_HARTS + 1)) == 32'd0)));

  p_prio_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (bus_addr[ADDR_W-1:12] == '0)) |-> ((bus_rdata >> PRIO_W) == 32'd0));

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_h
    p_claim_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && (bus_addr == ADDR_W'(32'h200004 + h * 32'h1000))) |->
        ((bus_rdata != 32'd0) == irq_out[h]));

    p_claim_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && (bus_addr == ADDR_W'(32'h200004 + h * 32'h1000))) |->
        (bus_rdata <= 32'(NUM_HARTS)));
  end
endmodule

bind swi_ctrl swi_ctrl_chk #(
  .NUM_HARTS(NUM_HARTS),
  .PRIO_W   (PRIO_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .irq_out  (irq_out)
);

// File: tb/swi_ctrl_bench.sv
module swi_ctrl_bench;
  localparam int N  = 4;
  localparam int PW = 3;
  localparam int AW = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irq_out;

  always #2 clk = ~clk;

  swi_ctrl #(.NUM_HARTS(N), .PRIO_W(PW), .ADDR_W(AW)) u_swi_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  int n_chk = 0;
  int n_fail = 0;

  int m_prio [1:N];
  bit m_pend [1:N];
  bit m_en   [N][1:N];
  bit m_busy [N][1:N];

  function automatic logic [AW-1:0] a_prio(int n); return AW'(4 * n); endfunction
  function automatic logic [AW-1:0] a_en(int h);   return AW'(32'h2000 + h * 32'h80); endfunction
  function automatic logic [AW-1:0] a_clm(int h);  return AW'(32'h200004 + h * 32'h1000); endfunction
  localparam logic [AW-1:0] A_PEND = AW'(32'h1000);

  function automatic bit m_elig(int h, int n);
    bit infl = 0;
    for (int k = 0; k < N; k++) infl |= m_busy[k][n];
    return m_pend[n] && m_en[h][n] && !infl && (m_prio[n] != 0);
  endfunction

  function automatic int m_win(int h);
    int best = 0;
    int bp = 0;
    for (int n = 1; n <= N; n++)
      if (m_elig(h, n) && m_prio[n] > bp) begin bp = m_prio[n]; best = n; end
    return best;
  endfunction

  function automatic logic [N-1:0] m_irq();
    logic [N-1:0] r = '0;
    for (int h = 0; h < N; h++)
      for (int n = 1; n <= N; n++) if (m_elig(h, n)) r[h] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] m_read(logic [AW-1:0] a);
    logic [31:0] r = '0;
    if (a == A_PEND) for (int n = 1; n <= N; n++) r[n] = m_pend[n];
    for (int n = 1; n <= N; n++) if (a == a_prio(n)) r = 32'(m_prio[n]);
    for (int h = 0; h < N; h++) begin
      if (a == a_en(h)) for (int n = 1; n <= N; n++) r[n] = m_en[h][n];
      if (a == a_clm(h)) r = 32'(m_win(h));
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_op(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    if (a == A_PEND) for (int n = 1; n <= N; n++) if (d[n]) m_pend[n] = 1;
    for (int n = 1; n <= N; n++) if (a == a_prio(n)) m_prio[n] = int'(d[PW-1:0]);
    for (int h = 0; h < N; h++) begin
      if (a == a_en(h)) for (int n = 1; n <= N; n++) m_en[h][n] = d[n];
      if (a == a_clm(h)) for (int n = 1; n <= N; n++) if (d == 32'(n)) m_busy[h][n] = 0;
    end
  endtask

  task automatic rd_op(logic [AW-1:0] a, string tag);
    logic [31:0] got;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 got = bus_rdata;
    chk(tag, got, m_read(a));
    @(negedge clk);
    bus_sel = 1'b0;
    for (int h = 0; h < N; h++)
      if (a == a_clm(h)) begin
        int w = m_win(h);
        if (w != 0) begin m_pend[w] = 0; m_busy[h][w] = 1; end
      end
  endtask

  task automatic irq_chk(string tag);
    #1 chk(tag, 32'(irq_out), 32'(m_irq()));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int n = 1; n <= N; n++) begin m_prio[n] = 0; m_pend[n] = 0; end
    for (int h = 0; h < N; h++)
      for (int n = 1; n <= N; n++) begin m_en[h][n] = 0; m_busy[h][n] = 0; end
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd_op(A_PEND, "R1 pending");
    rd_op(a_prio(1), "R1 priority");
    rd_op(a_en(0), "R1 enable");
    rd_op(a_clm(0), "R1 claim");
    irq_chk("R1 irq");

    // R3: priority storage and width
    for (int n = 1; n <= N; n++) wr_op(a_prio(n), 32'd1);
    wr_op(a_prio(2), 32'hFFFF_FFFF);
    rd_op(a_prio(2), "R3 truncated");
    wr_op(a_prio(2), 32'd1);
    rd_op(a_prio(2), "R3 readback");
    rd_op(AW'(0), "R3 offset zero");

    // R4: enables
    wr_op(a_en(0), 32'h2);
    wr_op(a_en(1), 32'hFFFF_FFFF);
    rd_op(a_en(0), "R4 enable h0");
    rd_op(a_en(1), "R4 enable h1 masked");
    irq_chk("R5 nothing pending");

    // R2: pending word
    wr_op(A_PEND, 32'h1);
    rd_op(A_PEND, "R2 bit0 hardwired");
    wr_op(A_PEND, 32'h2);
    rd_op(A_PEND, "R2 set bit1");
    wr_op(A_PEND, 32'h0);
    rd_op(A_PEND, "R2 zero write keeps");
    irq_chk("R5 raised");

    // R6/R7 claim
    rd_op(a_clm(0), "R6 claim source1");
    rd_op(A_PEND, "R6 pending cleared");
    irq_chk("R5 in service masks");
    rd_op(a_clm(0), "R7 empty claim");

    // R9 latched during service, R8 wrong completions
    wr_op(A_PEND, 32'h2);
    irq_chk("R9 held while in service");
    wr_op(a_clm(0), 32'd2);
    irq_chk("R8 wrong id ignored");
    wr_op(a_clm(1), 32'd1);
    irq_chk("R8 wrong hart ignored");
    wr_op(a_clm(0), 32'd1);
    irq_chk("R9 visible after completion");

    // R6 priority order and ties; priority zero excluded
    wr_op(a_prio(2), 32'd3);
    wr_op(a_prio(3), 32'd3);
    wr_op(a_prio(4), 32'd0);
    wr_op(A_PEND, 32'h1C);
    rd_op(a_clm(1), "R6 tie lowest id");
    rd_op(a_clm(1), "R6 second of tie");
    rd_op(a_clm(1), "R6 lower priority next");
    rd_op(a_clm(1), "R5 zero priority never eligible");
    for (int n = 1; n <= 3; n++) wr_op(a_clm(1), 32'(n));
    irq_chk("R8 completions");

    // R10 unmapped
    wr_op(AW'(32'h3000), 32'hFFFF_FFFF);
    rd_op(AW'(32'h3000), "R10 unmapped read");
    rd_op(AW'(32'h1002), "R10 misaligned read");
    wr_op(AW'(32'h2004), 32'hFFFF_FFFF);
    rd_op(a_en(0), "R10 no side effect");

    // Random mix
    for (int i = 0; i < 1500; i++) begin
      int k = int'($urandom_range(0, 7));
      int h = int'($urandom_range(0, N - 1));
      int n = int'($urandom_range(1, N));
      case (k)
        0: wr_op(A_PEND, $urandom & 32'h3E);
        1: wr_op(a_prio(n), 32'($urandom_range(0, 9)));
        2: wr_op(a_en(h), $urandom);
        3, 4: rd_op(a_clm(h), "R6 random claim");
        5: wr_op(a_clm(h), 32'($urandom_range(0, N + 1)));
        6: begin
          rd_op(A_PEND, "R2 random pending");
          rd_op(a_prio(n), "R3 random priority");
          rd_op(a_en(h), "R4 random enable");
        end
        default: begin
          wr_op(AW'(32'h4000 + 4 * n), $urandom);
          rd_op(AW'(32'h4000 + 4 * n), "R10 random unmapped");
        end
      endcase
      irq_chk("R5 random irq");
    end

    finish_run();
  end
endmodule